// File: doc/BRIEF.md
# Hysteresis Pattern Detector

This block watches a serial bit stream, one bit per clock, and drives a single level output. While the output is low, the block looks for the pattern 0,1,1,0. When that pattern completes, the output goes high. While the output is high, the block looks instead for the pattern 0,1,0, and that pattern drops the output back to low. The output keeps its level between these two events, so the block behaves like a latch with two different set and clear patterns.

The machine is a Mealy machine with seven states: four states track progress while the output is low, and three track progress while it is high. The output is a function of the state register and the current input bit. It therefore changes in the cycle that carries the final bit of a pattern. A registered copy of the output is also provided, for consumers that need a glitch-free level one cycle later.

Partial matches overlap. If a search fails, the longest suffix that still fits the pattern is kept. The closing 0 of either pattern also counts as the opening 0 of the pattern that is searched for next.

Top module: `hyst_seq_det`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, z_o is 0 for either value of x_i, and z_q_o is 0.
- R2: While the output is low, z_o becomes 1 in the cycle whose x_i is the final 0 of the input sequence 0,1,1,0. While the output is low, any x_i of 1 leaves z_o at 0.
- R3: Once z_o is 1, it remains 1 on every later cycle until the clearing sequence completes. This holds for any input that does not complete that sequence, including further 0,1,1,0 patterns.
- R4: While the output is high, z_o becomes 0 in the cycle whose x_i is the final 0 of the input sequence 0,1,0.
- R5: A failed partial match keeps its longest matching suffix. For example, 0,1,0,1,1,0 from reset raises z_o on the sixth bit.
- R6: The final 0 of a detected 0,1,1,0 also opens the clearing sequence, so a following 1,0 clears z_o on that 0.
- R7: The final 0 of a detected 0,1,0 also opens the trigger sequence, so a following 1,1,0 sets z_o on that 0.
- R8: On every clock edge after reset, z_q_o takes the value z_o had just before that edge.
- R9: From reset, the 24-bit input 0 0 1 0 0 0 1 1 0 0 1 0 1 0 1 1 0 0 0 0 0 1 0 1 yields z_o = 0 0 0 0 0 0 0 0 1 1 1 0 0 0 0 0 1 1 1 1 1 1 0 0.
- R10: z_o is combinational in x_i. After 0,1,1 with the output low, z_o follows the inverse of x_i within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one input bit is consumed per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Serial input bit |
| z_o | output | 1 | Mealy output level |
| z_q_o | output | 1 | z_o registered by one clock |

## Verification
A pattern's completion and the start of the opposite search fall in the same cycle: the single 0 that ends one pattern must also be counted as the first bit of the other. The bench provokes this with the back-to-back inputs 0,1,1,0,1,0 and 0,1,0,1,1,0. It judges the result by expecting z_o to flip exactly on each closing 0, and by checking that the next flip happens after only two or three more bits. A second overlap is tested by changing x_i mid-cycle in the state that sits one bit from the trigger. Here z_o is sampled before and after the change, and the registered copy must pick up the value from the last moment before the edge.

// File: rtl/hyst_seq_det_pkg.sv
package hyst_seq_det_pkg;
  localparam int unsigned StateW = 3;

  // low side: S0..S3, high side: S4..S6
  typedef enum logic [StateW-1:0] {
    S0 = 3'd0,  // low, no progress
    S1 = 3'd1,  // low, seen 0
    S2 = 3'd2,  // low, seen 01
    S3 = 3'd3,  // low, seen 011
    S4 = 3'd4,  // high, no progress
    S5 = 3'd5,  // high, seen 0
    S6 = 3'd6   // high, seen 01
  } state_e;
endpackage

// File: rtl/hyst_seq_det_next.sv
module hyst_seq_det_next
  import hyst_seq_det_pkg::*;
(
  input  state_e state_i,
  input  logic   x_i,
  output state_e state_o
);
  always_comb begin
    state_o = S0;
    unique case (state_i)
      S0: state_o = x_i ? S0 : S1;
      S1: state_o = x_i ? S2 : S1;
      S2: state_o = x_i ? S3 : S1;
      S3: state_o = x_i ? S0 : S5;  // trigger 0 seeds clear search
      S4: state_o = x_i ? S4 : S5;
      S5: state_o = x_i ? S6 : S5;
      S6: state_o = x_i ? S4 : S1;  // clear 0 seeds trigger search
      default: state_o = S0;
    endcase
  end
endmodule

// File: rtl/hyst_seq_det_out.sv
module hyst_seq_det_out
  import hyst_seq_det_pkg::*;
(
  input  state_e state_i,
  input  logic   x_i,
  output logic   z_o
);
  always_comb begin
    unique case (state_i)
      S0, S1, S2: z_o = 1'b0;
      S3:         z_o = ~x_i;
      S4, S5:     z_o = 1'b1;
      S6:         z_o = x_i;
      default:    z_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hyst_seq_det.sv
module hyst_seq_det
  import hyst_seq_det_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic z_o,
  output logic z_q_o
);
  state_e state_q, state_d;

  hyst_seq_det_next u_next (
    .state_i(state_q),
    .x_i    (x_i),
    .state_o(state_d)
  );

  hyst_seq_det_out u_out (
    .state_i(state_q),
    .x_i    (x_i),
    .z_o    (z_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S0;
      z_q_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      z_q_o   <= z_o;
    end
  end
endmodule

// File: rtl/hyst_seq_det_chk.sv
module hyst_seq_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic x_i,
  input logic z_o,
  input logic z_q_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R8
  z_q_tracks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0) |-> (z_q_o == $past(z_o)));

  // R2
  low_one_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!z_q_o && x_i) |-> !z_o);

  // R3
  high_one_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (z_q_o && x_i) |-> z_o);

  // R2
  rise_on_trigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !z_q_o && z_o) |->
      (!x_i && $past(x_i) && $past(x_i, 2) && !$past(x_i, 3)));

  // R4
  fall_on_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && z_q_o && !z_o) |->
      (!x_i && $past(x_i) && !$past(x_i, 2)));
endmodule

bind hyst_seq_det hyst_seq_det_chk chk_i (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .x_i   (x_i),
  .z_o   (z_o),
  .z_q_o (z_q_o)
);

// File: tb/hyst_seq_det_tb_top.sv
`timescale 1ns/1ps
module hyst_seq_det_tb_top;
  localparam int unsigned NVec = 24;
  // R9 reference vectors, index 0 first
  localparam logic [NVec-1:0] RefX = 24'b101000001101010011000100;
  localparam logic [NVec-1:0] RefZ = 24'b001111110000011100000000;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic x = 1'b0;
  logic z, z_q;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hyst_seq_det dut_i (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .x_i   (x),
    .z_o   (z),
    .z_q_o (z_q)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, check z_o mid-cycle, then registered copy after edge
  task automatic step(input logic xv, input logic exp, input string tag);
    @(negedge clk);
    x = xv;
    #1;
    check(z, exp, tag);
    @(posedge clk);
    #1;
    check(z_q, exp, "R8");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    x = 1'b1;
    #1;
    check(z, 1'b0, "R1");
    check(z_q, 1'b0, "R1");
    x = 1'b0;
    #1;
    check(z, 1'b0, "R1");
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1 first cycle after release, x=1
    step(1'b1, 1'b0, "R1");
    do_reset();

    // R9 reference trace
    for (int i = 0; i < NVec; i++) step(RefX[i], RefZ[i], "R9");

    // R5 overlapping partial match
    do_reset();
    step(1'b0, 1'b0, "R5"); step(1'b1, 1'b0, "R5"); step(1'b0, 1'b0, "R5");
    step(1'b1, 1'b0, "R5"); step(1'b1, 1'b0, "R5"); step(1'b0, 1'b1, "R5");
    // R6 trigger's 0 opens clear
    step(1'b1, 1'b1, "R6"); step(1'b0, 1'b0, "R6");
    // R7 clear's 0 opens trigger
    step(1'b1, 1'b0, "R7"); step(1'b1, 1'b0, "R7"); step(1'b0, 1'b1, "R7");
    // R3 hold high through non-clearing input, including 0110
    step(1'b1, 1'b1, "R3"); step(1'b1, 1'b1, "R3"); step(1'b0, 1'b1, "R3");
    step(1'b0, 1'b1, "R3"); step(1'b1, 1'b1, "R3"); step(1'b1, 1'b1, "R3");
    step(1'b0, 1'b1, "R3"); step(1'b1, 1'b1, "R3"); step(1'b1, 1'b1, "R3");
    step(1'b1, 1'b1, "R3");
    // R4 clear
    step(1'b0, 1'b1, "R4"); step(1'b1, 1'b1, "R4"); step(1'b0, 1'b0, "R4");
    // R2 low: near misses stay low
    step(1'b1, 1'b0, "R2"); step(1'b1, 1'b0, "R2"); step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, "R2"); step(1'b0, 1'b0, "R2"); step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b0, "R2"); step(1'b1, 1'b0, "R2");

    // R10 mid-cycle input change one bit from trigger
    do_reset();
    step(1'b0, 1'b0, "R10"); step(1'b1, 1'b0, "R10"); step(1'b1, 1'b0, "R10");
    @(negedge clk);
    x = 1'b0;
    #1;
    check(z, 1'b1, "R10");
    x = 1'b1;
    #1;
    check(z, 1'b0, "R10");
    x = 1'b0;
    #1;
    check(z, 1'b1, "R10");
    x = 1'b1;
    #1;
    check(z, 1'b0, "R10");
    @(posedge clk);
    #1;
    check(z_q, 1'b0, "R8");
    step(1'b0, 1'b0, "R10");

    // R1 reset while high
    step(1'b1, 1'b0, "R2"); step(1'b1, 1'b0, "R2"); step(1'b0, 1'b1, "R2");
    @(negedge clk);
    rst_ni = 1'b0;
    x = 1'b1;
    #1;
    check(z, 1'b0, "R1");
    check(z_q, 1'b0, "R1");
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b0, 1'b0, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule